// File: doc/BRIEF.md
# Aliased MMIO Register Read Decoder

This block answers reads into a 128 KiB memory-mapped window of a control block. The register values live elsewhere and arrive as input ports. The decoder takes a read request and picks the addressed value. It registers the data and a response flag, so each result comes out one cycle after its request.

The window is made of two 64 KiB pages, and the upper page mirrors the lower one. Registers that are 64 bits wide can be read in one 8-byte access. They can also be read as two 4-byte halves. Offsets with no register behind them return zero with a good response. Write requests are not supported: each write gets an error response.

Top module: `mmio_rd_decode`

## Requirements
- R1: Address bit 16 is ignored. A read at A with bit 16 set returns the same data and status as the read at A with bit 16 clear.
- R2: A read whose `req_size` (in bytes) is neither 4 nor 8 gets `rsp_err`=1 and `rsp_data`=0.
- R3: Every write request (`req_write`=1) gets `rsp_err`=1 and `rsp_data`=0, whatever its address and size.
- R4: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. `rsp_data` and `rsp_err` belong to that request.
- R5: For 4-byte reads at page offsets 0x00 to 0x14, `rsp_data[31:0]` is identification word number offset/4, taken from bits [32*i+31:32*i] of `id_words_i`.
- R6: 4-byte reads return these 32-bit inputs:
  - 0x18 `impl_id_i`
  - 0x20 `ctrl0_i`
  - 0x24 `ctrl0_done_i`
  - 0x28 `ctrl1_i`
  - 0x2C `ctrl2_i`
  - 0x40 `status_i`
  - 0x60 `fault_flags_i`
  - 0x64 `fault_ack_i`
  - 0x88 `stream_cfg_i`
  - 0x98 `cmdq_wr_idx_i`
  - 0x9C `cmdq_rd_idx_i`
  - 0xA8 `evtq_wr_idx_i`
  - 0xAC `evtq_rd_idx_i`
- R7: 4-byte reads at 0x50 and at 0x54 both return `irq_ctl_i`.
- R8: The 64-bit registers sit at these offsets:
  - 0x68 `fault_irq_addr_i`
  - 0x80 `stream_base_i`
  - 0x90 `cmdq_base_i`
  - 0xA0 `evtq_base_i`

  A 4-byte read at a register's offset returns bits [31:0] of that register. A 4-byte read at offset+4 returns bits [63:32].
- R9: An 8-byte read at any of the four offsets in R8 returns the whole 64-bit value, little-endian, with the low half in `rsp_data[31:0]` and `rsp_err`=0.
- R10: An 8-byte read at any other offset returns `rsp_data`=0 with `rsp_err`=0.
- R11: A 4-byte read at an offset not named in R5 to R8 returns 0 with `rsp_err`=0. Every 4-byte read returns `rsp_data[63:32]`=0.
- R12: While reset is held and before the first request, `rsp_valid`, `rsp_err` and `rsp_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request is a write |
| req_addr | input | 17 | Byte address in the window |
| req_size | input | 4 | Access size in bytes |
| id_words_i | input | 192 | Six identification words, word 0 in the low bits |
| impl_id_i | input | 32 | Implementation identity |
| ctrl0_i | input | 32 | Control word 0 |
| ctrl0_done_i | input | 32 | Control word 0 acknowledge |
| ctrl1_i | input | 32 | Control word 1 |
| ctrl2_i | input | 32 | Control word 2 |
| status_i | input | 32 | Status word |
| irq_ctl_i | input | 32 | Interrupt control, also shown as its acknowledge |
| fault_flags_i | input | 32 | Global fault flags |
| fault_ack_i | input | 32 | Global fault acknowledge flags |
| fault_irq_addr_i | input | 64 | Fault interrupt target address |
| stream_base_i | input | 64 | Stream table base |
| stream_cfg_i | input | 32 | Stream table configuration |
| cmdq_base_i | input | 64 | Command queue base |
| cmdq_wr_idx_i | input | 32 | Command queue producer index |
| cmdq_rd_idx_i | input | 32 | Command queue consumer index |
| evtq_base_i | input | 64 | Event queue base |
| evtq_wr_idx_i | input | 32 | Event queue producer index |
| evtq_rd_idx_i | input | 32 | Event queue consumer index |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 64 | Read data |
| rsp_err | output | 1 | Error response |

## Verification
Each result has one register between the request and the outputs. A request presented before rising edge N therefore shows up on `rsp_valid`, `rsp_data` and `rsp_err` right after edge N. The bench drives each request on a falling edge and reads the outputs on the next falling edge, halfway between the capturing edge and the following one. It then drops `req_valid` and checks, one falling edge later, that `rsp_valid` has gone low. Register inputs hold fixed, distinct patterns throughout, so a wrong selection or a swapped half shows up as a data mismatch.

// File: rtl/mmio_rd_pkg.sv
package mmio_rd_pkg;

   localparam int OFF_W = 16;
   typedef logic [OFF_W-1:0] off_t;

   // Page offsets (software decodes these, so they are fixed).
   localparam off_t OFS_IMPL       = 16'h0018;
   localparam off_t OFS_CTRL0      = 16'h0020;
   localparam off_t OFS_CTRL0_DONE = 16'h0024;
   localparam off_t OFS_CTRL1      = 16'h0028;
   localparam off_t OFS_CTRL2      = 16'h002C;
   localparam off_t OFS_STATUS     = 16'h0040;
   localparam off_t OFS_IRQ_CTL    = 16'h0050;
   localparam off_t OFS_IRQ_DONE   = 16'h0054;
   localparam off_t OFS_FAULT      = 16'h0060;
   localparam off_t OFS_FAULT_ACK  = 16'h0064;
   localparam off_t OFS_FAULT_IRQ  = 16'h0068;
   localparam off_t OFS_STREAM     = 16'h0080;
   localparam off_t OFS_STREAM_CFG = 16'h0088;
   localparam off_t OFS_CMDQ       = 16'h0090;
   localparam off_t OFS_CMDQ_WR    = 16'h0098;
   localparam off_t OFS_CMDQ_RD    = 16'h009C;
   localparam off_t OFS_EVTQ       = 16'h00A0;
   localparam off_t OFS_EVTQ_WR    = 16'h00A8;
   localparam off_t OFS_EVTQ_RD    = 16'h00AC;

   typedef enum logic [1:0] {
      ACC_WORD  = 2'd0,
      ACC_DWORD = 2'd1,
      ACC_BAD   = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/mmio_rd_word_mux.sv
module mmio_rd_word_mux
   import mmio_rd_pkg::*;
#(
   parameter int NUM_ID = 6,
   parameter int WORD_W = 32
) (
   input  off_t                     off,
   input  logic [NUM_ID*WORD_W-1:0] id_words,
   input  logic [WORD_W-1:0]        impl_id,
   input  logic [WORD_W-1:0]        ctrl0,
   input  logic [WORD_W-1:0]        ctrl0_done,
   input  logic [WORD_W-1:0]        ctrl1,
   input  logic [WORD_W-1:0]        ctrl2,
   input  logic [WORD_W-1:0]        status,
   input  logic [WORD_W-1:0]        irq_ctl,
   input  logic [WORD_W-1:0]        fault_flags,
   input  logic [WORD_W-1:0]        fault_ack,
   input  logic [2*WORD_W-1:0]      fault_irq_addr,
   input  logic [2*WORD_W-1:0]      stream_base,
   input  logic [WORD_W-1:0]        stream_cfg,
   input  logic [2*WORD_W-1:0]      cmdq_base,
   input  logic [WORD_W-1:0]        cmdq_wr_idx,
   input  logic [WORD_W-1:0]        cmdq_rd_idx,
   input  logic [2*WORD_W-1:0]      evtq_base,
   input  logic [WORD_W-1:0]        evtq_wr_idx,
   input  logic [WORD_W-1:0]        evtq_rd_idx,
   output logic [WORD_W-1:0]        word
);

   localparam off_t ID_LAST = off_t'((NUM_ID - 1) * 4);

   logic                           in_id_range;
   logic [NUM_ID-1:0][WORD_W-1:0]  id_terms;
   logic [WORD_W-1:0]              id_word;
   logic [WORD_W-1:0]              reg_word;

   assign in_id_range = (off <= ID_LAST);

   // One gated term per identification word, OR-reduced below.
   for (genvar gi = 0; gi < NUM_ID; gi++) begin : g_id
      assign id_terms[gi] = (in_id_range && (off[OFF_W-1:2] == (OFF_W-2)'(gi)))
                            ? id_words[gi*WORD_W +: WORD_W] : '0;
   end

   always_comb begin
      id_word = '0;
      for (int k = 0; k < NUM_ID; k++) id_word = id_word | id_terms[k];
   end

   always_comb begin
      case (off)
         OFS_IMPL:           reg_word = impl_id;
         OFS_CTRL0:          reg_word = ctrl0;
         OFS_CTRL0_DONE:     reg_word = ctrl0_done;
         OFS_CTRL1:          reg_word = ctrl1;
         OFS_CTRL2:          reg_word = ctrl2;
         OFS_STATUS:         reg_word = status;
         OFS_IRQ_CTL,
         OFS_IRQ_DONE:       reg_word = irq_ctl;
         OFS_FAULT:          reg_word = fault_flags;
         OFS_FAULT_ACK:      reg_word = fault_ack;
         OFS_FAULT_IRQ:      reg_word = fault_irq_addr[WORD_W-1:0];
         OFS_FAULT_IRQ + 4:  reg_word = fault_irq_addr[2*WORD_W-1:WORD_W];
         OFS_STREAM:         reg_word = stream_base[WORD_W-1:0];
         OFS_STREAM + 4:     reg_word = stream_base[2*WORD_W-1:WORD_W];
         OFS_STREAM_CFG:     reg_word = stream_cfg;
         OFS_CMDQ:           reg_word = cmdq_base[WORD_W-1:0];
         OFS_CMDQ + 4:       reg_word = cmdq_base[2*WORD_W-1:WORD_W];
         OFS_CMDQ_WR:        reg_word = cmdq_wr_idx;
         OFS_CMDQ_RD:        reg_word = cmdq_rd_idx;
         OFS_EVTQ:           reg_word = evtq_base[WORD_W-1:0];
         OFS_EVTQ + 4:       reg_word = evtq_base[2*WORD_W-1:WORD_W];
         OFS_EVTQ_WR:        reg_word = evtq_wr_idx;
         OFS_EVTQ_RD:        reg_word = evtq_rd_idx;
         default:            reg_word = '0;
      endcase
   end

   // Identification range and the named offsets never overlap.
   assign word = in_id_range ? id_word : reg_word;

endmodule

// File: rtl/mmio_rd_dword_mux.sv
module mmio_rd_dword_mux
   import mmio_rd_pkg::*;
#(
   parameter int DW = 64
) (
   input  off_t          off,
   input  logic [DW-1:0] fault_irq_addr,
   input  logic [DW-1:0] stream_base,
   input  logic [DW-1:0] cmdq_base,
   input  logic [DW-1:0] evtq_base,
   output logic [DW-1:0] dword
);

   always_comb begin
      case (off)
         OFS_FAULT_IRQ: dword = fault_irq_addr;
         OFS_STREAM:    dword = stream_base;
         OFS_CMDQ:      dword = cmdq_base;
         OFS_EVTQ:      dword = evtq_base;
         default:       dword = '0;
      endcase
   end

endmodule

// File: rtl/mmio_rd_decode.sv
module mmio_rd_decode
   import mmio_rd_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int SIZE_W   = 4,
   parameter int WORD_W   = 32,
   parameter int NUM_ID   = 6,
   parameter bit ALIAS_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [SIZE_W-1:0]        req_size,
   input  logic [NUM_ID*WORD_W-1:0] id_words_i,
   input  logic [WORD_W-1:0]        impl_id_i,
   input  logic [WORD_W-1:0]        ctrl0_i,
   input  logic [WORD_W-1:0]        ctrl0_done_i,
   input  logic [WORD_W-1:0]        ctrl1_i,
   input  logic [WORD_W-1:0]        ctrl2_i,
   input  logic [WORD_W-1:0]        status_i,
   input  logic [WORD_W-1:0]        irq_ctl_i,
   input  logic [WORD_W-1:0]        fault_flags_i,
   input  logic [WORD_W-1:0]        fault_ack_i,
   input  logic [2*WORD_W-1:0]      fault_irq_addr_i,
   input  logic [2*WORD_W-1:0]      stream_base_i,
   input  logic [WORD_W-1:0]        stream_cfg_i,
   input  logic [2*WORD_W-1:0]      cmdq_base_i,
   input  logic [WORD_W-1:0]        cmdq_wr_idx_i,
   input  logic [WORD_W-1:0]        cmdq_rd_idx_i,
   input  logic [2*WORD_W-1:0]      evtq_base_i,
   input  logic [WORD_W-1:0]        evtq_wr_idx_i,
   input  logic [WORD_W-1:0]        evtq_rd_idx_i,
   output logic                     rsp_valid,
   output logic [2*WORD_W-1:0]      rsp_data,
   output logic                     rsp_err
);

   localparam int DW         = 2 * WORD_W;
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int DW_BYTES   = DW / 8;
   localparam int HI_W       = ADDR_W - OFF_W;

   initial begin
      if (ADDR_W <= OFF_W)
         $error("ADDR_W must exceed the page offset width");
      if (WORD_W != 32)
         $error("WORD_W must be 32");
      if (NUM_ID < 1 || NUM_ID > 6)
         $error("NUM_ID must be 1..6");
      if (DW_BYTES >= (1 << SIZE_W))
         $error("SIZE_W too narrow for an 8-byte size");
   end

   // ---------------- address aliasing ----------------
   logic [ADDR_W-1:0] eff_addr;

   if (ALIAS_EN) begin : g_alias
      assign eff_addr = req_addr & ~(ADDR_W'(1) << OFF_W);
   end else begin : g_no_alias
      assign eff_addr = req_addr;
   end

   off_t            off;
   logic [HI_W-1:0] hi_bits;
   logic            in_page;

   assign off     = eff_addr[OFF_W-1:0];
   assign hi_bits = eff_addr[ADDR_W-1:OFF_W];
   assign in_page = (hi_bits == '0);

   // ---------------- access classification ----------------
   acc_kind_e kind;

   always_comb begin
      if (req_size == SIZE_W'(WORD_BYTES))    kind = ACC_WORD;
      else if (req_size == SIZE_W'(DW_BYTES)) kind = ACC_DWORD;
      else                                    kind = ACC_BAD;
   end

   // ---------------- selection ----------------
   logic [WORD_W-1:0] word_sel;
   logic [DW-1:0]     dword_sel;

   mmio_rd_word_mux #(
      .NUM_ID (NUM_ID),
      .WORD_W (WORD_W)
   ) u_word (
      .off            (off),
      .id_words       (id_words_i),
      .impl_id        (impl_id_i),
      .ctrl0          (ctrl0_i),
      .ctrl0_done     (ctrl0_done_i),
      .ctrl1          (ctrl1_i),
      .ctrl2          (ctrl2_i),
      .status         (status_i),
      .irq_ctl        (irq_ctl_i),
      .fault_flags    (fault_flags_i),
      .fault_ack      (fault_ack_i),
      .fault_irq_addr (fault_irq_addr_i),
      .stream_base    (stream_base_i),
      .stream_cfg     (stream_cfg_i),
      .cmdq_base      (cmdq_base_i),
      .cmdq_wr_idx    (cmdq_wr_idx_i),
      .cmdq_rd_idx    (cmdq_rd_idx_i),
      .evtq_base      (evtq_base_i),
      .evtq_wr_idx    (evtq_wr_idx_i),
      .evtq_rd_idx    (evtq_rd_idx_i),
      .word           (word_sel)
   );

   mmio_rd_dword_mux #(
      .DW (DW)
   ) u_dword (
      .off            (off),
      .fault_irq_addr (fault_irq_addr_i),
      .stream_base    (stream_base_i),
      .cmdq_base      (cmdq_base_i),
      .evtq_base      (evtq_base_i),
      .dword          (dword_sel)
   );

   // ---------------- response formation ----------------
   logic [DW-1:0] nxt_data;
   logic          nxt_err;

   always_comb begin
      nxt_data = '0;
      nxt_err  = 1'b0;
      if (req_write) begin
         nxt_err = 1'b1;
      end else begin
         case (kind)
            ACC_WORD:  nxt_data = in_page ? {{WORD_W{1'b0}}, word_sel} : '0;
            ACC_DWORD: nxt_data = in_page ? dword_sel : '0;
            default:   nxt_err  = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_data <= nxt_data;
            rsp_err  <= nxt_err;
         end
      end
   end

   // ---------------- assertions ----------------
   a_r4_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r3_write_errors: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_err && rsp_data == '0));

   a_r2_bad_size_errors: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size != SIZE_W'(WORD_BYTES) && req_size != SIZE_W'(DW_BYTES))
      |=> (rsp_err && rsp_data == '0));

   a_r11_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == SIZE_W'(WORD_BYTES))
      |=> (!rsp_err && rsp_data[DW-1:WORD_W] == '0));

   a_r7_irq_pair_same: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == SIZE_W'(WORD_BYTES) && in_page &&
       (off == OFS_IRQ_CTL || off == OFS_IRQ_DONE))
      |=> (rsp_data[WORD_W-1:0] == $past(irq_ctl_i)));

endmodule

// File: tb/mmio_rd_decode_tb.sv
module mmio_rd_decode_tb;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [16:0]   req_addr = '0;
   logic [3:0]    req_size = '0;
   logic [191:0]  id_words;
   logic [31:0]   impl_id, ctrl0, ctrl0_done, ctrl1, ctrl2, status, irq_ctl;
   logic [31:0]   fault_flags, fault_ack, stream_cfg;
   logic [31:0]   cmdq_wr, cmdq_rd, evtq_wr, evtq_rd;
   logic [63:0]   fault_irq, stream_base, cmdq_base, evtq_base;
   logic          rsp_valid;
   logic [63:0]   rsp_data;
   logic          rsp_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   mmio_rd_decode u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .id_words_i(id_words),
      .impl_id_i(impl_id), .ctrl0_i(ctrl0), .ctrl0_done_i(ctrl0_done),
      .ctrl1_i(ctrl1), .ctrl2_i(ctrl2), .status_i(status), .irq_ctl_i(irq_ctl),
      .fault_flags_i(fault_flags), .fault_ack_i(fault_ack),
      .fault_irq_addr_i(fault_irq), .stream_base_i(stream_base),
      .stream_cfg_i(stream_cfg), .cmdq_base_i(cmdq_base),
      .cmdq_wr_idx_i(cmdq_wr), .cmdq_rd_idx_i(cmdq_rd), .evtq_base_i(evtq_base),
      .evtq_wr_idx_i(evtq_wr), .evtq_rd_idx_i(evtq_rd),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
   );

   initial begin
      for (int i = 0; i < 6; i++) id_words[i*32 +: 32] = 32'h1D00_0000 + i * 32'h0101;
      impl_id     = 32'h0000_4A11;
      ctrl0       = 32'hC000_0001;
      ctrl0_done  = 32'hC0AC_0002;
      ctrl1       = 32'hC111_0003;
      ctrl2       = 32'hC222_0004;
      status      = 32'h5757_0005;
      irq_ctl     = 32'h1E1E_0006;
      fault_flags = 32'hFA17_0007;
      fault_ack   = 32'hFA0C_0008;
      stream_cfg  = 32'h5C0F_0009;
      cmdq_wr     = 32'h0000_0A0A;
      cmdq_rd     = 32'h0000_0B0B;
      evtq_wr     = 32'h0000_0C0C;
      evtq_rd     = 32'h0000_0D0D;
      fault_irq   = 64'h8888_7777_6666_5555;
      stream_base = 64'h1234_5678_9ABC_DEF0;
      cmdq_base   = 64'hCAFE_0001_BEEF_0002;
      evtq_base   = 64'hE0E0_1111_E1E1_2222;
   end

   // Expected 4-byte value per R5..R8 and R11.
   function automatic logic [31:0] exp_word(input logic [15:0] o);
      if (o <= 16'h0014) return id_words[(o >> 2) * 32 +: 32];
      case (o)
         16'h18: return impl_id;
         16'h20: return ctrl0;
         16'h24: return ctrl0_done;
         16'h28: return ctrl1;
         16'h2C: return ctrl2;
         16'h40: return status;
         16'h50, 16'h54: return irq_ctl;
         16'h60: return fault_flags;
         16'h64: return fault_ack;
         16'h68: return fault_irq[31:0];
         16'h6C: return fault_irq[63:32];
         16'h80: return stream_base[31:0];
         16'h84: return stream_base[63:32];
         16'h88: return stream_cfg;
         16'h90: return cmdq_base[31:0];
         16'h94: return cmdq_base[63:32];
         16'h98: return cmdq_wr;
         16'h9C: return cmdq_rd;
         16'hA0: return evtq_base[31:0];
         16'hA4: return evtq_base[63:32];
         16'hA8: return evtq_wr;
         16'hAC: return evtq_rd;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Drive on a falling edge, sample on the next one (one register of latency).
   task automatic access(input logic w, input logic [16:0] a, input logic [3:0] sz,
                         output logic [63:0] d, output logic e, output logic v);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz;
      @(negedge clk);
      d = rsp_data; e = rsp_err; v = rsp_valid;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic t_reset;
      check("R12 valid", {63'b0, rsp_valid}, 64'd0);
      check("R12 data", rsp_data, 64'd0);
      check("R12 err", {63'b0, rsp_err}, 64'd0);
   endtask

   task automatic t_latency;
      logic [63:0] d; logic e, v;
      access(1'b0, 17'h00020, 4'd4, d, e, v);
      check("R4 valid after req", {63'b0, v}, 64'd1);
      @(negedge clk);
      check("R4 valid drops", {63'b0, rsp_valid}, 64'd0);
   endtask

   task automatic t_ids;
      logic [63:0] d; logic e, v;
      for (int i = 0; i < 6; i++) begin
         access(1'b0, 17'(i * 4), 4'd4, d, e, v);
         check("R5 id word", d, {32'h0, id_words[i*32 +: 32]});
      end
      access(1'b0, 17'h00015, 4'd4, d, e, v);
      check("R11 past id range", d, 64'd0);
   endtask

   task automatic t_words;
      logic [63:0] d; logic e, v;
      logic [15:0] offs [13] = '{16'h18, 16'h20, 16'h24, 16'h28, 16'h2C, 16'h40,
                                 16'h60, 16'h64, 16'h88, 16'h98, 16'h9C, 16'hA8, 16'hAC};
      for (int i = 0; i < 13; i++) begin
         access(1'b0, {1'b0, offs[i]}, 4'd4, d, e, v);
         check("R6 word reg", d, {32'h0, exp_word(offs[i])});
         check("R6 err", {63'b0, e}, 64'd0);
      end
   endtask

   task automatic t_irq_pair;
      logic [63:0] d; logic e, v;
      access(1'b0, 17'h00050, 4'd4, d, e, v);
      check("R7 irq ctl", d, {32'h0, irq_ctl});
      access(1'b0, 17'h00054, 4'd4, d, e, v);
      check("R7 irq ack", d, {32'h0, irq_ctl});
   endtask

   task automatic t_halves;
      logic [63:0] d; logic e, v;
      logic [15:0] bases [4] = '{16'h68, 16'h80, 16'h90, 16'hA0};
      for (int i = 0; i < 4; i++) begin
         access(1'b0, {1'b0, bases[i]}, 4'd4, d, e, v);
         check("R8 low half", d, {32'h0, exp_word(bases[i])});
         access(1'b0, {1'b0, bases[i] + 16'h4}, 4'd4, d, e, v);
         check("R8 high half", d, {32'h0, exp_word(bases[i] + 16'h4)});
      end
   endtask

   task automatic t_dwords;
      logic [63:0] d; logic e, v;
      access(1'b0, 17'h00068, 4'd8, d, e, v); check("R9 fault irq", d, fault_irq);
      access(1'b0, 17'h00080, 4'd8, d, e, v); check("R9 stream", d, stream_base);
      access(1'b0, 17'h00090, 4'd8, d, e, v); check("R9 cmdq", d, cmdq_base);
      access(1'b0, 17'h000A0, 4'd8, d, e, v); check("R9 evtq", d, evtq_base);
      check("R9 err", {63'b0, e}, 64'd0);
   endtask

   task automatic t_dword_other;
      logic [63:0] d; logic e, v;
      access(1'b0, 17'h00020, 4'd8, d, e, v);
      check("R10 data", d, 64'd0); check("R10 err", {63'b0, e}, 64'd0);
      access(1'b0, 17'h00088, 4'd8, d, e, v);
      check("R10 data cfg", d, 64'd0);
   endtask

   task automatic t_unmapped;
      logic [63:0] d; logic e, v;
      access(1'b0, 17'h00030, 4'd4, d, e, v);
      check("R11 data", d, 64'd0); check("R11 err", {63'b0, e}, 64'd0);
      access(1'b0, 17'h0FFFC, 4'd4, d, e, v);
      check("R11 far data", d, 64'd0);
   endtask

   task automatic t_alias;
      logic [63:0] d; logic e, v;
      access(1'b0, 17'h10020, 4'd4, d, e, v);
      check("R1 alias word", d, {32'h0, ctrl0}); check("R1 alias err", {63'b0, e}, 64'd0);
      access(1'b0, 17'h10090, 4'd8, d, e, v);
      check("R1 alias dword", d, cmdq_base);
      access(1'b0, 17'h10004, 4'd4, d, e, v);
      check("R1 alias id", d, {32'h0, id_words[63:32]});
   endtask

   task automatic t_bad_size;
      logic [63:0] d; logic e, v;
      logic [3:0] sizes [4] = '{4'd0, 4'd1, 4'd2, 4'd15};
      for (int i = 0; i < 4; i++) begin
         access(1'b0, 17'h00020, sizes[i], d, e, v);
         check("R2 err", {63'b0, e}, 64'd1);
         check("R2 data", d, 64'd0);
      end
   endtask

   task automatic t_write;
      logic [63:0] d; logic e, v;
      access(1'b1, 17'h00020, 4'd4, d, e, v);
      check("R3 err word", {63'b0, e}, 64'd1); check("R3 data", d, 64'd0);
      access(1'b1, 17'h00080, 4'd8, d, e, v);
      check("R3 err dword", {63'b0, e}, 64'd1); check("R3 data dword", d, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_latency;
      t_ids;
      t_words;
      t_irq_pair;
      t_halves;
      t_dwords;
      t_dword_other;
      t_unmapped;
      t_alias;
      t_bad_size;
      t_write;
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule